// File: doc/BRIEF.md
# Sampled Audio Channel Sequencer

One channel of a sampled-sound engine. The channel receives 16-bit sample words, either from a DMA engine or written directly by a processor, and plays each word as two 8-bit samples, the high byte first. A down-counting period counter sets how many ticks each byte stays on the sample output. A length counter tracks the words of a DMA block. The channel raises one-cycle interrupt requests and one-cycle DMA requests.

A five-state sequencer drives playback. The states are idle, priming, fetching, high byte and low byte. Processor-fed playback goes from idle straight to the high byte and requests an interrupt as it starts. DMA-fed playback first takes a dummy word in the priming state, then fetches the first real word. After that it runs words back to back for as long as DMA stays enabled and no interrupt is pending. The sequencer moves only on cycles where the single-cycle `tick` enable is high. Register writes are accepted on any cycle.

Top module: `audio_chan_seq`

## Requirements
- R1: After reset the channel is idle, `sample` is 0, `irq_req` and `dma_req` are 0 and `vol_out` is 0. `sample` is 0 whenever the channel is not playing a byte.
- R2: When idle with a word held, `dma_en` low and `irq_pend` low, a tick moves to the high byte. This loads the playback buffer from the held word, reloads the period counter and pulses `irq_req` for one cycle.
- R3: While `irq_pend` is high, an idle channel with a held word and DMA off does not start. The word stays held and plays once `irq_pend` falls.
- R4: The byte on `sample` is the buffer's bits [15:8] in the high state and bits [7:0] in the low state. Each byte is held for P ticks, where P is the period register (0 acts as 1). In processor mode the channel returns to idle after the low byte.
- R5: The sequencer changes state only on ticks. A period write made during playback takes effect at the next period reload.
- R6: A tick with `dma_en` high while idle enters priming, reloads both counters and pulses `dma_req`. A held word on a tick in priming moves to fetching, consumes the word and pulses `dma_req`. It also pulses `irq_req` if the length register equals 1.
- R7: In priming or fetching, a tick with `dma_en` low returns to idle.
- R8: In fetching, a held word on a tick moves to the high byte. This loads the buffer, reloads the period counter and pulses `dma_req`.
- R9: When the low byte expires with `dma_en` high and `irq_pend` low, the next held word is loaded, the high byte starts and `dma_req` pulses. Otherwise the channel goes idle.
- R10: The length counter decrements on each low-to-high continuation. If it is already 1, it reloads and `irq_req` pulses instead. With length L, every L-th continuation raises an interrupt.
- R11: Requests are enabled when (`att_vol` OR NOT `att_per`). When they are disabled, `irq_req` and `dma_req` stay low but state transitions are unchanged.
- R12: `vol_out` takes the volume register value on every entry to the high byte and holds it otherwise.
- R13: A data write sets the held-word flag, and consuming a word clears it. A write on the same cycle as a consume wins. An idle channel without a new write does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle advance enable for the sequencer |
| per_wr | input | 1 | Period back-up latch write strobe |
| per_val | input | 16 | Period value |
| len_wr | input | 1 | Length back-up latch write strobe |
| len_val | input | 16 | Length value in words |
| vol_wr | input | 1 | Volume latch write strobe |
| vol_val | input | 7 | Volume value |
| dat_wr | input | 1 | Data word write strobe (sets held-word flag) |
| dat_val | input | 16 | Data word |
| dma_en | input | 1 | DMA enabled for this channel |
| irq_pend | input | 1 | Interrupt still pending for this channel |
| att_vol | input | 1 | Volume attach active |
| att_per | input | 1 | Period attach active |
| irq_req | output | 1 | One-cycle interrupt request |
| dma_req | output | 1 | One-cycle request for the next data word |
| sample | output | 8 | Current 8-bit sample |
| vol_out | output | 7 | Volume applied to the current word |

## Verification
The hardest situation to reach is the length-driven interrupt on a low-to-high continuation. It needs a primed DMA block, several words fed back to back at the right cycles, and DMA kept on across byte expiries. The bench plays the DMA engine. It writes the dummy word and the first word, then writes each following word on the tick after the high byte starts. It sweeps length 1 to 3, period 1 and 2, and all four attach combinations. It counts continuations to predict on which one `irq_req` must pulse. Separate runs drop DMA in each waiting state and raise `irq_pend` before a low-byte expiry to force the idle exits.

// File: rtl/audio_chan_pkg.sv
package audio_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRIME = 3'd1,
        ST_FETCH = 3'd2,
        ST_HI    = 3'd3,
        ST_LO    = 3'd4
    } seq_state_e;

    function automatic logic req_allowed(input logic att_v, input logic att_p);
        return (!att_v && !att_p) || att_v;
    endfunction

endpackage

// File: rtl/acs_word_hold.sv
module acs_word_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] val,
    input  logic          take,
    output logic [DW-1:0] word,
    output logic          full
);
    typedef struct packed {
        logic [DW-1:0] word;
        logic          full;
    } hold_s;

    hold_s q, d;

    always_comb begin
        d = q;
        if (take) d.full = 1'b0;
        if (wr) begin
            d.full = 1'b1;
            d.word = val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word = q.word;
    assign full = q.full;

    assert_fill_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> full);

    assert_take_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> !full);

endmodule

// File: rtl/acs_timers.sv
module acs_timers #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          per_wr,
    input  logic [CW-1:0] per_val,
    input  logic          len_wr,
    input  logic [CW-1:0] len_val,
    input  logic          per_reload,
    input  logic          per_dec,
    input  logic          len_reload,
    input  logic          len_dec,
    output logic          per_fin,
    output logic          len_fin,
    output logic          len_one
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] per_bak;
        logic [CW-1:0] per_cnt;
        logic [CW-1:0] len_bak;
        logic [CW-1:0] len_cnt;
    } tmr_s;

    tmr_s q, d;

    always_comb begin
        d = q;
        if (per_reload)                 d.per_cnt = q.per_bak;
        else if (per_dec && q.per_cnt != '0) d.per_cnt = q.per_cnt - ONE;
        if (len_reload)                 d.len_cnt = q.len_bak;
        else if (len_dec && q.len_cnt != '0) d.len_cnt = q.len_cnt - ONE;
        if (per_wr) d.per_bak = per_val;
        if (len_wr) d.len_bak = len_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign per_fin = (q.per_cnt <= ONE);
    assign len_fin = (q.len_cnt <= ONE);
    assign len_one = (q.len_bak == ONE);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_dec && !per_reload && q.per_cnt > ONE) |=> q.per_cnt == $past(q.per_cnt) - ONE);

    assert_len_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (len_dec && !len_reload && q.len_cnt > ONE) |=> q.len_cnt == $past(q.len_cnt) - ONE);

endmodule

// File: rtl/acs_sequencer.sv
module acs_sequencer
    import audio_chan_pkg::*;
#(
    parameter int DW = 16,
    parameter int VW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            full,
    input  logic [DW-1:0]   word,
    input  logic            dma_en,
    input  logic            irq_pend,
    input  logic            req_en,
    input  logic            per_fin,
    input  logic            len_fin,
    input  logic            len_one,
    input  logic            vol_wr,
    input  logic [VW-1:0]   vol_val,
    output logic            take,
    output logic            per_reload,
    output logic            per_dec,
    output logic            len_reload,
    output logic            len_dec,
    output logic            irq_req,
    output logic            dma_req,
    output logic [DW/2-1:0] sample,
    output logic [VW-1:0]   vol_out
);
    localparam int SW = DW / 2;

    typedef struct packed {
        seq_state_e    st;
        logic [DW-1:0] buf_w;
        logic [VW-1:0] vol_bak;
        logic [VW-1:0] vol;
        logic          irq;
        logic          dma;
    } seq_s;

    seq_s q, d;
    seq_state_e st_q;

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        d.dma      = 1'b0;
        take       = 1'b0;
        per_reload = 1'b0;
        per_dec    = 1'b0;
        len_reload = 1'b0;
        len_dec    = 1'b0;
        if (vol_wr) d.vol_bak = vol_val;
        if (tick) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (full && !dma_en && !irq_pend) begin
                        d.st       = ST_HI;
                        d.buf_w    = word;
                        d.vol      = q.vol_bak;
                        take       = 1'b1;
                        per_reload = 1'b1;
                        d.irq      = req_en;
                    end else if (dma_en) begin
                        d.st       = ST_PRIME;
                        per_reload = 1'b1;
                        len_reload = 1'b1;
                        d.dma      = req_en;
                    end
                end
                ST_PRIME: begin
                    if (!dma_en) begin
                        d.st = ST_IDLE;
                    end else if (full) begin
                        d.st  = ST_FETCH;
                        take  = 1'b1;
                        d.dma = req_en;
                        if (len_one) begin
                            len_reload = 1'b1;
                            d.irq      = req_en;
                        end
                    end
                end
                ST_FETCH: begin
                    if (!dma_en) begin
                        d.st = ST_IDLE;
                    end else if (full) begin
                        d.st       = ST_HI;
                        d.buf_w    = word;
                        d.vol      = q.vol_bak;
                        take       = 1'b1;
                        per_reload = 1'b1;
                        d.dma      = req_en;
                    end
                end
                ST_HI: begin
                    if (per_fin) begin
                        d.st       = ST_LO;
                        per_reload = 1'b1;
                    end else begin
                        per_dec = 1'b1;
                    end
                end
                ST_LO: begin
                    if (per_fin) begin
                        if (dma_en && !irq_pend) begin
                            d.st       = ST_HI;
                            d.buf_w    = word;
                            d.vol      = q.vol_bak;
                            take       = 1'b1;
                            per_reload = 1'b1;
                            d.dma      = req_en;
                            if (len_fin) begin
                                len_reload = 1'b1;
                                d.irq      = req_en;
                            end else begin
                                len_dec = 1'b1;
                            end
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        per_dec = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_HI:   sample = q.buf_w[DW-1:SW];
            ST_LO:   sample = q.buf_w[SW-1:0];
            default: sample = '0;
        endcase
    end

    assign st_q    = q.st;
    assign irq_req = q.irq;
    assign dma_req = q.dma;
    assign vol_out = q.vol;

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HI && st_q != ST_LO) |-> sample == '0);

    assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    assert_hi_to_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && per_fin && st_q == ST_HI) |=> st_q == ST_LO);

    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q));

    assert_wait_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dma_en && (st_q == ST_PRIME || st_q == ST_FETCH)) |=> st_q == ST_IDLE);

    assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |=> !(irq_req || dma_req));

    assert_vol_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(vol_out));

endmodule

// File: rtl/audio_chan_seq.sv
module audio_chan_seq #(
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int VW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            per_wr,
    input  logic [CW-1:0]   per_val,
    input  logic            len_wr,
    input  logic [CW-1:0]   len_val,
    input  logic            vol_wr,
    input  logic [VW-1:0]   vol_val,
    input  logic            dat_wr,
    input  logic [DW-1:0]   dat_val,
    input  logic            dma_en,
    input  logic            irq_pend,
    input  logic            att_vol,
    input  logic            att_per,
    output logic            irq_req,
    output logic            dma_req,
    output logic [DW/2-1:0] sample,
    output logic [VW-1:0]   vol_out
);
    logic          take, full, req_en;
    logic [DW-1:0] word;
    logic          per_reload, per_dec, len_reload, len_dec;
    logic          per_fin, len_fin, len_one;

    assign req_en = audio_chan_pkg::req_allowed(att_vol, att_per);

    acs_word_hold #(.DW(DW)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (dat_wr),
        .val  (dat_val),
        .take (take),
        .word (word),
        .full (full)
    );

    acs_timers #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_wr    (per_wr),
        .per_val   (per_val),
        .len_wr    (len_wr),
        .len_val   (len_val),
        .per_reload(per_reload),
        .per_dec   (per_dec),
        .len_reload(len_reload),
        .len_dec   (len_dec),
        .per_fin   (per_fin),
        .len_fin   (len_fin),
        .len_one   (len_one)
    );

    acs_sequencer #(.DW(DW), .VW(VW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .full      (full),
        .word      (word),
        .dma_en    (dma_en),
        .irq_pend  (irq_pend),
        .req_en    (req_en),
        .per_fin   (per_fin),
        .len_fin   (len_fin),
        .len_one   (len_one),
        .vol_wr    (vol_wr),
        .vol_val   (vol_val),
        .take      (take),
        .per_reload(per_reload),
        .per_dec   (per_dec),
        .len_reload(len_reload),
        .len_dec   (len_dec),
        .irq_req   (irq_req),
        .dma_req   (dma_req),
        .sample    (sample),
        .vol_out   (vol_out)
    );

endmodule

// File: tb/audio_chan_seq_test.sv
`timescale 1ns/1ps
module audio_chan_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        per_wr = 1'b0, len_wr = 1'b0, vol_wr = 1'b0, dat_wr = 1'b0;
    logic [15:0] per_val = '0, len_val = '0, dat_val = '0;
    logic [6:0]  vol_val = '0;
    logic        dma_en = 1'b0, irq_pend = 1'b0, att_vol = 1'b0, att_per = 1'b0;
    logic        irq_req, dma_req;
    logic [7:0]  sample;
    logic [6:0]  vol_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    audio_chan_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .per_wr(per_wr), .per_val(per_val), .len_wr(len_wr), .len_val(len_val),
        .vol_wr(vol_wr), .vol_val(vol_val), .dat_wr(dat_wr), .dat_val(dat_val),
        .dma_en(dma_en), .irq_pend(irq_pend), .att_vol(att_vol), .att_per(att_per),
        .irq_req(irq_req), .dma_req(dma_req), .sample(sample), .vol_out(vol_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [15:0] dv);
        tick = t; dat_wr = w; dat_val = dv;
        @(posedge clk); #1;
        tick = 1'b0; dat_wr = 1'b0;
    endtask

    task automatic wr_reg(input int which, input logic [15:0] v);
        case (which)
            0: begin per_wr = 1'b1; per_val = v; end
            1: begin len_wr = 1'b1; len_val = v; end
            default: begin vol_wr = 1'b1; vol_val = v[6:0]; end
        endcase
        @(posedge clk); #1;
        per_wr = 1'b0; len_wr = 1'b0; vol_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; dat_wr = 1'b0; dma_en = 1'b0;
        irq_pend = 1'b0; att_vol = 1'b0; att_per = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    function automatic logic [15:0] dword(input int n, input int a, input int b);
        return {8'(n * 16 + a), 8'(n * 16 + 8 + b)};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 sample", 32'(sample), 0);
        chk("R1 irq", 32'(irq_req), 0);
        chk("R1 dma", 32'(dma_req), 0);
        chk("R1 vol", 32'(vol_out), 0);

        // R2 R4 R11 R12 R13: processor-fed sweep over period and attach modes
        for (int p = 0; p <= 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                int pe;
                logic re;
                logic [15:0] w;
                pe = (p == 0) ? 1 : p;
                re = (c[1] == 1'b0) || (c[0] == 1'b1);
                w  = dword(p, c, c);
                do_reset();
                att_vol = c[0]; att_per = c[1];
                wr_reg(0, 16'(p));
                wr_reg(2, 16'(p * 4 + c));
                cyc(1'b0, 1'b1, w);
                chk("R5 no tick idle", 32'(sample), 0);
                cyc(1'b1, 1'b0, 16'h0);
                chk("R2 start hi", 32'(sample), 32'(w[15:8]));
                chk("R11 irq gate", 32'(irq_req), 32'(re));
                chk("R2 no dma", 32'(dma_req), 0);
                chk("R12 vol load", 32'(vol_out), 32'(p * 4 + c));
                for (int k = 2; k <= 2 * pe + 2; k++) begin
                    logic [7:0] ex;
                    cyc(1'b1, 1'b0, 16'h0);
                    ex = (k <= pe) ? w[15:8] : (k <= 2 * pe) ? w[7:0] : 8'h00;
                    chk("R4 byte timing", 32'(sample), 32'(ex));
                    chk("R2 irq one cycle", 32'(irq_req), 0);
                end
                chk("R13 no restart", 32'(sample), 0);
            end
        end

        // R3 pending interrupt blocks a processor start
        do_reset();
        wr_reg(0, 16'd2);
        irq_pend = 1'b1;
        cyc(1'b0, 1'b1, 16'hC3D4);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 16'h0);
            chk("R3 blocked", 32'(sample), 0);
            chk("R3 no irq", 32'(irq_req), 0);
        end
        irq_pend = 1'b0;
        cyc(1'b1, 1'b0, 16'h0);
        chk("R3 word kept", 32'(sample), 32'hC3);
        chk("R3 irq", 32'(irq_req), 1);

        // R5 R12 R13 tick gating, writes during playback
        do_reset();
        wr_reg(0, 16'd3);
        wr_reg(2, 16'd5);
        cyc(1'b0, 1'b1, 16'h1234);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R5 hi", 32'(sample), 32'h12);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b0, 16'h0);
            chk("R5 hold no tick", 32'(sample), 32'h12);
        end
        wr_reg(2, 16'd9);
        chk("R12 vol held", 32'(vol_out), 5);
        wr_reg(0, 16'd1);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R5 hi k2", 32'(sample), 32'h12);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R5 hi k3", 32'(sample), 32'h12);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R5 lo new period", 32'(sample), 32'h34);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R5 idle after one", 32'(sample), 0);
        cyc(1'b0, 1'b1, 16'h5678);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R13 restart", 32'(sample), 32'h56);
        chk("R12 new vol", 32'(vol_out), 9);
        chk("R2 irq restart", 32'(irq_req), 1);

        // R6 R8 R9 R10 R11 DMA sweep
        for (int L = 1; L <= 3; L++) begin
            for (int p = 1; p <= 2; p++) begin
                for (int c = 0; c < 4; c++) begin
                    logic re;
                    int t;
                    re = (c[1] == 1'b0) || (c[0] == 1'b1);
                    t = 0;
                    do_reset();
                    att_vol = c[0]; att_per = c[1];
                    wr_reg(0, 16'(p));
                    wr_reg(1, 16'(L));
                    dma_en = 1'b1;
                    cyc(1'b1, 1'b0, 16'h0);
                    chk("R6 prime dma", 32'(dma_req), 32'(re));
                    chk("R6 prime quiet", 32'(sample), 0);
                    chk("R6 prime irq", 32'(irq_req), 0);
                    cyc(1'b0, 1'b1, 16'hA5A5);
                    cyc(1'b1, 1'b0, 16'h0);
                    chk("R6 fetch dma", 32'(dma_req), 32'(re));
                    chk("R6 len1 irq", 32'(irq_req), 32'((L == 1) && re));
                    chk("R6 fetch quiet", 32'(sample), 0);
                    cyc(1'b0, 1'b1, dword(1, L, p));
                    cyc(1'b1, 1'b0, 16'h0);
                    chk("R8 first hi", 32'(sample), 32'(dword(1, L, p) >> 8));
                    chk("R8 dma", 32'(dma_req), 32'(re));
                    for (int n = 1; n <= 4; n++) begin
                        logic [15:0] cur;
                        cur = dword(n, L, p);
                        for (int k = 2; k <= 2 * p; k++) begin
                            logic [7:0] ex;
                            if (k == 2 && n == 4) dma_en = 1'b0;
                            cyc(1'b1, (k == 2) && (n != 4), dword(n + 1, L, p));
                            ex = (k <= p) ? cur[15:8] : cur[7:0];
                            chk("R4 dma byte", 32'(sample), 32'(ex));
                            chk("R9 no dma mid", 32'(dma_req), 0);
                        end
                        cyc(1'b1, 1'b0, 16'h0);
                        if (n != 4) begin
                            t++;
                            chk("R9 continue hi", 32'(sample), 32'(dword(n + 1, L, p) >> 8));
                            chk("R9 continue dma", 32'(dma_req), 32'(re));
                            chk("R10 block irq", 32'(irq_req), 32'(re && (t % L == 0)));
                        end else begin
                            chk("R9 stop idle", 32'(sample), 0);
                            chk("R9 stop no dma", 32'(dma_req), 0);
                        end
                    end
                    cyc(1'b1, 1'b0, 16'h0);
                    chk("R9 stays idle", 32'(sample), 0);
                    chk("R9 stays no dma", 32'(dma_req), 0);
                end
            end
        end

        // R7 drop DMA while priming
        do_reset();
        wr_reg(0, 16'd1);
        dma_en = 1'b1;
        cyc(1'b1, 1'b0, 16'h0);
        dma_en = 1'b0;
        cyc(1'b1, 1'b0, 16'h0);
        cyc(1'b0, 1'b1, 16'h7788);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R7 prime exit", 32'(sample), 32'h77);
        chk("R7 prime exit irq", 32'(irq_req), 1);

        // R7 drop DMA while fetching
        do_reset();
        wr_reg(0, 16'd1);
        dma_en = 1'b1;
        cyc(1'b1, 1'b0, 16'h0);
        cyc(1'b0, 1'b1, 16'h1111);
        cyc(1'b1, 1'b0, 16'h0);
        dma_en = 1'b0;
        cyc(1'b1, 1'b0, 16'h0);
        chk("R7 fetch exit quiet", 32'(sample), 0);
        cyc(1'b0, 1'b1, 16'h99AA);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R7 fetch exit", 32'(sample), 32'h99);
        chk("R7 fetch exit irq", 32'(irq_req), 1);

        // R9 pending interrupt stops DMA continuation
        do_reset();
        wr_reg(0, 16'd1);
        wr_reg(1, 16'd4);
        dma_en = 1'b1;
        cyc(1'b1, 1'b0, 16'h0);
        cyc(1'b0, 1'b1, 16'h0);
        cyc(1'b1, 1'b0, 16'h0);
        cyc(1'b0, 1'b1, 16'hBBCC);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R8 hi", 32'(sample), 32'hBB);
        cyc(1'b1, 1'b1, 16'hDDEE);
        chk("R4 lo", 32'(sample), 32'hCC);
        irq_pend = 1'b1;
        cyc(1'b1, 1'b0, 16'h0);
        chk("R9 pend idle", 32'(sample), 0);
        chk("R9 pend no dma", 32'(dma_req), 0);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R6 reprime dma", 32'(dma_req), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule